// File: doc/BRIEF.md
# Port-Width Adapting Bus Sequencer

This block takes one processor-side request and plays it out as a series of beats on a multiplexed address/data bus. A request is a read or a write of one datum (byte, halfword or word) or a read of a four-word block. Each memory region has its own port width of 8, 16 or 32 bits. The block splits a wide datum into narrow beats and reassembles read bytes into processor words. The four low address outputs step through the bytes as the beats go by. External memory finishes each beat by raising an acknowledge input.

Every transaction starts with a one-cycle address strobe. An optional address hold cycle can follow it. Idle turnaround cycles are inserted when the bus direction changes. A read-side data enable tells memory when it may drive the bus. Programmable strobes can be set to follow reads, writes or both. A diagnostic pin reports the miss/uncached flag during the address part of a read and the instruction/data flag during its data part. Three strap inputs are captured while reset is held. They set the width of region 0 (the boot region) and switch on the address hold cycle.

Requests are naturally aligned. Region 0 takes its width from the straps. Every other region takes its 2-bit width code from `cfg_width`: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits.

Top module: `portw_bus_seq`

## Requirements
- R1: Each accepted request gives exactly one `ale` cycle. In that cycle `ad_oe` is high and `ad_out` carries the request address, with bits 3:0 forced to zero for a block read.
- R2: A single-datum transfer starts `addr_lo` at the exact address bits 3:0. Each beat moves min(port bytes, datum bytes) bytes, and `addr_lo` steps by that amount. A beat ends only on a cycle with `ack` high.
- R3: A four-word block read starts `addr_lo` at 0 and steps it by the port width until 16 bytes have moved. `rvalid` pulses once per completed word, four times in all.
- R4: Read bytes are packed into `rdata` at their processor lanes, with unused lanes at zero. `done` and the final `rvalid` are high together in the cycle after the last acknowledged beat, and `req_ready` is high in that cycle.
- R5: On a write, each datum byte is placed on the bus lane that matches its address and the port width. `be` marks exactly the lanes that are driven.
- R6: `rd_en` is high only during read data beats, and `ad_oe` is low whenever `rd_en` is high. Both are low while idle and after reset. `rd_en` stays low for the whole of a write.
- R7: When the previous transaction went the other way, `cfg_turn` idle cycles come between acceptance and `ale`. When it went the same way, `ale` follows acceptance directly.
- R8: With the hold strap set, one extra cycle follows `ale`. In that cycle `ad_oe` stays high and the address stays on `ad_out`, and data beats start one cycle later than without the strap.
- R9: Strobe i follows `cfg_strb[2i]` on read data beats and `cfg_strb[2i+1]` on write data beats. It is low outside data beats.
- R10: On reads, `diag` is high in the address phase for a cache miss (kind 1 or 2) and low for uncached (kind 0 or 3). In data beats it is high only for an instruction miss (kind 1).
- R11: Straps are sampled while `rst_n` is low and held after release. Bit 0 set gives region 0 an 8-bit width. Otherwise bit 1 set gives it 16 bits, and with neither bit set it is 32 bits. Bit 2 enables the address hold cycle.
- R12: An instruction miss is always a block read. A data miss is a block read when `cfg_dref4` is 1 and a single word otherwise. An uncached read or any write moves `req_size` (0 byte, 1 halfword, 2 or 3 word).
- R13: For byte address x with port width W, the bus lane is x mod W in little-endian and 3 − (x mod W) in big-endian (`cfg_big`). The processor lane is x mod 4, or 3 − (x mod 4) in big-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 3 | Reset-time straps: boot 8-bit, boot 16-bit, address hold |
| cfg_width | input | 2*NREG | Width codes for each region |
| cfg_big | input | 1 | Big-endian lane order |
| cfg_dref4 | input | 1 | Data miss refills four words |
| cfg_turn | input | TURNW | Turnaround idle cycles |
| cfg_strb | input | 2*NSTB | Per-strobe mode: read bit, write bit |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_size | input | 2 | Datum size code |
| req_kind | input | 2 | 0 uncached, 1 instruction miss, 2 data miss |
| req_addr | input | 32 | Request byte address |
| req_region | input | RGW | Target region index |
| req_wdata | input | 32 | Write datum in processor lanes |
| req_ready | output | 1 | Idle, request will be taken |
| done | output | 1 | Request finished |
| rvalid | output | 1 | `rdata` holds a completed word |
| rdata | output | 32 | Packed read word |
| ale | output | 1 | Address latch strobe |
| ad_oe | output | 1 | Block drives the A/D bus |
| ad_out | output | 32 | A/D bus output value |
| ad_in | input | 32 | A/D bus input value |
| rd_en | output | 1 | Memory may drive the bus |
| addr_lo | output | 4 | Low address of the current datum byte |
| be | output | 4 | Active byte lanes of the beat |
| diag | output | 1 | Multiplexed diagnostic |
| strb | output | NSTB | Programmable strobes |
| ack | input | 1 | Memory completes the beat |

## Verification
Two functions meet on the final beat of a read. The last packed word, its `rvalid` and `done` all appear in one cycle, and the block is ready for a new request in that same cycle. A narrow-port read runs with `ack` held back on alternate cycles. The bench checks that stalled cycles neither step `addr_lo` nor corrupt the word, and that `done` lines up with the final word. The second overlap is between a direction change and the hold strap. Both stretch the gap around `ale`. The bench measures the gap from acceptance to `ale` and from `ale` to the first beat separately, and judges each against its own setting.

// File: rtl/portw_bus_seq.sv
module portw_bus_seq #(
  parameter int NREG  = 4,
  parameter int NSTB  = 2,
  parameter int TURNW = 2,
  localparam int RGW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  input  logic [2*NREG-1:0] cfg_width,
  input  logic              cfg_big,
  input  logic              cfg_dref4,
  input  logic [TURNW-1:0]  cfg_turn,
  input  logic [2*NSTB-1:0] cfg_strb,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_kind,
  input  logic [31:0]       req_addr,
  input  logic [RGW-1:0]    req_region,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              ale,
  output logic              ad_oe,
  output logic [31:0]       ad_out,
  input  logic [31:0]       ad_in,
  output logic              rd_en,
  output logic [3:0]        addr_lo,
  output logic [3:0]        be,
  output logic              diag,
  output logic [NSTB-1:0]   strb,
  input  logic              ack
);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_ADDR, S_HOLD, S_DATA} st_t;

  function automatic logic [2:0] code_bytes(input logic [1:0] c);
    case (c)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  st_t             st;
  logic [2:0]      strap_q;
  logic [27:0]     hi_q;
  logic [3:0]      lo_q;
  logic [4:0]      rem_q;
  logic [2:0]      pw_q;
  logic            wr_q;
  logic [1:0]      kind_q;
  logic [31:0]     wd_q, acc_q;
  logic [TURNW-1:0] tcnt;
  logic            prev_vld, prev_wr;

  logic [1:0] rcode;
  assign rcode = (req_region == '0) ? (strap_q[0] ? 2'd0 : strap_q[1] ? 2'd1 : 2'd2)
                                    : cfg_width[req_region*2 +: 2];

  wire       blk_r = !req_write && (req_kind == 2'd1 || (req_kind == 2'd2 && cfg_dref4));
  wire       sub_r = req_write || req_kind == 2'd0 || req_kind == 2'd3;
  wire [2:0] sz_r  = sub_r ? code_bytes(req_size) : 3'd4;
  wire [4:0] len_r = blk_r ? 5'd16 : {2'b0, sz_r};

  wire [2:0] nb    = ({2'b0, pw_q} < rem_q) ? pw_q : rem_q[2:0];
  wire       last  = ({2'b0, nb} == rem_q);
  wire [3:0] lo_nx = lo_q + {1'b0, nb};
  wire       wend  = last || (lo_nx[1:0] == 2'd0);
  wire [1:0] pmask = pw_q[1:0] - 2'd1;

  logic [3:0]  be_c;
  logic [31:0] wbus, accn;
  always_comb begin
    logic [3:0] x;
    logic [1:0] xm, lb, lc;
    be_c = '0;
    wbus = '0;
    accn = acc_q;
    for (int k = 0; k < 4; k++) begin
      x  = lo_q + 4'(k);
      xm = x[1:0] & pmask;
      lb = cfg_big ? 2'd3 - xm : xm;
      lc = cfg_big ? 2'd3 - x[1:0] : x[1:0];
      if (3'(k) < nb) begin
        be_c[lb]          = 1'b1;
        wbus[lb*8 +: 8]   = wd_q[lc*8 +: 8];
        accn[lc*8 +: 8]   = ad_in[lb*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      strap_q  <= strap_i;
      prev_vld <= 1'b0;
      prev_wr  <= 1'b0;
      done     <= 1'b0;
      rvalid   <= 1'b0;
      rdata    <= '0;
      acc_q    <= '0;
      tcnt     <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      rem_q    <= '0;
      pw_q     <= 3'd4;
      wr_q     <= 1'b0;
      kind_q   <= '0;
      wd_q     <= '0;
    end else begin
      done   <= 1'b0;
      rvalid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          hi_q     <= req_addr[31:4];
          lo_q     <= blk_r ? 4'd0 : req_addr[3:0];
          rem_q    <= len_r;
          pw_q     <= code_bytes(rcode);
          wr_q     <= req_write;
          kind_q   <= req_kind;
          wd_q     <= req_wdata;
          acc_q    <= '0;
          tcnt     <= cfg_turn;
          prev_vld <= 1'b1;
          prev_wr  <= req_write;
          st <= (prev_vld && prev_wr != req_write && cfg_turn != '0) ? S_TURN : S_ADDR;
        end
        S_TURN: if (tcnt <= TURNW'(1)) st <= S_ADDR; else tcnt <= tcnt - TURNW'(1);
        S_ADDR: st <= strap_q[2] ? S_HOLD : S_DATA;
        S_HOLD: st <= S_DATA;
        S_DATA: if (ack) begin
          lo_q  <= lo_nx;
          rem_q <= rem_q - {2'b0, nb};
          if (!wr_q) begin
            if (wend) begin
              acc_q  <= '0;
              rdata  <= accn;
              rvalid <= 1'b1;
            end else begin
              acc_q <= accn;
            end
          end
          if (last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire in_addr = (st == S_ADDR) || (st == S_HOLD);
  wire in_data = (st == S_DATA);

  assign req_ready = (st == S_IDLE);
  assign ale       = (st == S_ADDR);
  assign ad_oe     = in_addr || (in_data && wr_q);
  assign rd_en     = in_data && !wr_q;
  assign ad_out    = in_addr ? {hi_q, lo_q} : (in_data && wr_q) ? wbus : '0;
  assign addr_lo   = lo_q;
  assign be        = in_data ? be_c : '0;
  assign diag      = !wr_q && ((in_addr && (kind_q == 2'd1 || kind_q == 2'd2)) ||
                               (in_data && kind_q == 2'd1));

  for (genvar i = 0; i < NSTB; i++) begin : g_strb
    assign strb[i] = in_data && (wr_q ? cfg_strb[2*i+1] : cfg_strb[2*i]);
  end

endmodule

// File: rtl/portw_bus_seq_chk.sv
module portw_bus_seq_chk #(
  parameter int NSTB = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            ad_oe,
  input logic            rd_en,
  input logic            req_ready,
  input logic            done,
  input logic [3:0]      be,
  input logic [NSTB-1:0] strb
);

  p_ale_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);

  p_ale_drive_r1: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe);

  p_rden_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (!ad_oe && !ale));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rd_en && !ad_oe && be == 4'd0));

  p_done_ready_r4: assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready);

  p_strb_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb) |-> (|be));

  p_lane_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|be) |-> ($countones(be) != 3));

endmodule

bind portw_bus_seq portw_bus_seq_chk #(.NSTB(NSTB)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ad_oe(ad_oe), .rd_en(rd_en),
  .req_ready(req_ready), .done(done), .be(be), .strb(strb)
);

// File: tb/portw_bus_seq_tb.sv
module portw_bus_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap_i = 3'b000;
  logic [7:0]  cfg_width = 8'b00_01_10_10;
  logic        tb_big = 1'b0;
  logic        cfg_dref4 = 1'b0;
  logic [1:0]  cfg_turn = 2'd0;
  logic [3:0]  cfg_strb = 4'b10_01;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0, req_kind = 2'd0, req_region = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, done, rvalid, ale, ad_oe, rd_en, diag, ack = 1'b1;
  logic [31:0] rdata, ad_out, ad_in;
  logic [3:0]  addr_lo, be;
  logic [1:0]  strb;

  int          tb_w = 4;
  logic [27:0] cap_hi = '0;

  int checks = 0, errors = 0;

  int          nbeat, nrv, nale, t_ale, t_data;
  logic [3:0]  bt_lo [16];
  logic [3:0]  bt_be [16];
  logic [31:0] bt_dat [16];
  logic [31:0] rv [4];
  logic [31:0] ale_addr, hold_addr;
  logic        hold_oe, diag_a, diag_d;
  logic [1:0]  strb_d;

  always #10 clk = ~clk;

  portw_bus_seq #(.NREG(4), .NSTB(2), .TURNW(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cfg_width(cfg_width),
    .cfg_big(tb_big), .cfg_dref4(cfg_dref4), .cfg_turn(cfg_turn), .cfg_strb(cfg_strb),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_kind(req_kind), .req_addr(req_addr), .req_region(req_region),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rvalid(rvalid),
    .rdata(rdata), .ale(ale), .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in),
    .rd_en(rd_en), .addr_lo(addr_lo), .be(be), .diag(diag), .strb(strb), .ack(ack)
  );

  function automatic int lbf(int x, int w, bit big);
    int xm = x % w;
    return big ? 3 - xm : xm;
  endfunction

  function automatic int lcf(int x, bit big);
    return big ? 3 - (x % 4) : x % 4;
  endfunction

  function automatic logic [7:0] memb(logic [31:0] a);
    return 8'(a * 13 + 33);
  endfunction

  always_comb begin
    ad_in = '0;
    for (int j = 0; j < 4; j++) begin
      if (j < tb_w) begin
        int x;
        x = (int'(addr_lo) & ~(tb_w - 1)) + j;
        ad_in[lbf(x, tb_w, tb_big)*8 +: 8] = memb({cap_hi, 4'(x)});
      end
    end
  end

  task automatic chk(string tg, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tg, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    strap_i = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_i = 3'b000;
  endtask

  task automatic run(bit wr, logic [1:0] sz, logic [1:0] kd, logic [31:0] a,
                     logic [1:0] rg, logic [31:0] wd, bit stall);
    bit fin = 0;
    nbeat = 0; nrv = 0; nale = 0; t_ale = -1; t_data = -1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_kind = kd;
    req_addr = a; req_region = rg; req_wdata = wd; ack = 1'b1;
    for (int t = 1; t < 300; t++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (ale) begin
        nale++;
        if (t_ale < 0) begin
          t_ale = t; ale_addr = ad_out; cap_hi = ad_out[31:4]; diag_a = diag;
        end
      end
      if (t_ale > 0 && t == t_ale + 1) begin
        hold_oe = ad_oe; hold_addr = ad_out;
      end
      if ((|be) && t_data < 0) begin
        t_data = t; diag_d = diag; strb_d = strb;
      end
      if ((|be) && ack && nbeat < 16) begin
        bt_lo[nbeat] = addr_lo; bt_be[nbeat] = be; bt_dat[nbeat] = ad_out; nbeat++;
      end
      if (rvalid && nrv < 4) begin
        rv[nrv] = rdata; nrv++;
      end
      if (done) begin
        chk("R4 ready with done", 32'(req_ready), 32'd1);
        fin = 1;
        break;
      end
      ack = stall ? ((t % 2) == 1) : 1'b1;
    end
    ack = 1'b1;
    chk("R2 transaction completes", 32'(fin), 32'd1);
    chk("R1 one ale", 32'(nale), 32'd1);
  endtask

  task automatic expect_seq(string tg, int w, int a, int s, bit wr, logic [31:0] wd);
    int n = (s < w) ? s : w;
    chk({tg, " beats"}, 32'(nbeat), 32'(s / n));
    for (int i = 0; i < s / n && i < 16; i++) begin
      int lo;
      logic [3:0] eb;
      eb = '0;
      lo = (a + i * n) % 16;
      for (int k = 0; k < n; k++) eb[lbf(lo + k, w, tb_big)] = 1'b1;
      chk({tg, " addr_lo"}, 32'(bt_lo[i]), 32'(lo));
      chk({tg, " be"}, 32'(bt_be[i]), 32'(eb));
      if (wr)
        for (int k = 0; k < n; k++)
          chk({tg, " R5 lane"}, 32'(bt_dat[i][lbf(lo + k, w, tb_big)*8 +: 8]),
              32'(wd[lcf(lo + k, tb_big)*8 +: 8]));
    end
    if (!wr && s < 16) begin
      logic [31:0] e = '0;
      for (int k = 0; k < s; k++) begin
        int x = (a + k) % 16;
        e[lcf(x, tb_big)*8 +: 8] = memb({cap_hi, 4'(x)});
      end
      chk({tg, " R4 rvalid count"}, 32'(nrv), 32'd1);
      chk({tg, " R4 rdata"}, rv[0], e);
    end
    if (s == 16) begin
      chk({tg, " R3 word count"}, 32'(nrv), 32'd4);
      for (int j = 0; j < 4; j++) begin
        logic [31:0] e = '0;
        for (int b = 0; b < 4; b++)
          e[lcf(4*j + b, tb_big)*8 +: 8] = memb({cap_hi, 4'(4*j + b)});
        chk({tg, " R3 word"}, rv[j], e);
      end
    end
  endtask

  task automatic t_reset;
    chk("R6 reset rd_en", 32'(rd_en), 32'd0);
    chk("R6 reset ad_oe", 32'(ad_oe), 32'd0);
    chk("R1 reset ale", 32'(ale), 32'd0);
    chk("R4 reset done", 32'(done), 32'd0);
    chk("R4 reset ready", 32'(req_ready), 32'd1);
    chk("R9 reset strb", 32'(strb), 32'd0);
  endtask

  task automatic t_word32;
    tb_w = 4; tb_big = 0;
    run(0, 2'd2, 2'd0, 32'h0000_1238, 2'd1, '0, 0);
    expect_seq("R2 word32", 4, 32'h1238, 4, 0, '0);
    chk("R1 ale address", ale_addr, 32'h0000_1238);
    chk("R7 no turn gap", 32'(t_ale), 32'd1);
    chk("R10 uncached addr diag", 32'(diag_a), 32'd0);
    chk("R10 uncached data diag", 32'(diag_d), 32'd0);
    chk("R9 read strobe", 32'(strb_d), 32'b01);
  endtask

  task automatic t_pack8_stall;
    tb_w = 1; tb_big = 0;
    run(0, 2'd2, 2'd0, 32'h0000_2004, 2'd3, '0, 1);
    expect_seq("R2 word8 stalled", 1, 32'h2004, 4, 0, '0);
  endtask

  task automatic t_byte16;
    tb_w = 2; tb_big = 0;
    run(0, 2'd0, 2'd0, 32'h0000_5003, 2'd2, '0, 0);
    expect_seq("R13 byte16 le", 2, 32'h5003, 1, 0, '0);
  endtask

  task automatic t_writes;
    tb_w = 2; tb_big = 1;
    run(1, 2'd1, 2'd0, 32'h0000_3006, 2'd2, 32'hA1B2_C3D4, 0);
    expect_seq("R13 half16 be write", 2, 32'h3006, 2, 1, 32'hA1B2_C3D4);
    chk("R9 write strobe", 32'(strb_d), 32'b10);
    tb_w = 1; tb_big = 1;
    run(1, 2'd2, 2'd0, 32'h0000_0040, 2'd3, 32'h1122_3344, 0);
    expect_seq("R5 word8 be write", 1, 32'h40, 4, 1, 32'h1122_3344);
    tb_w = 1; tb_big = 0;
    run(1, 2'd2, 2'd0, 32'h0000_0048, 2'd3, 32'h5566_7788, 0);
    expect_seq("R5 word8 le write", 1, 32'h48, 4, 1, 32'h5566_7788);
  endtask

  task automatic t_block;
    tb_w = 2; tb_big = 0;
    run(0, 2'd2, 2'd1, 32'h0000_6008, 2'd2, '0, 0);
    expect_seq("R3 block16", 2, 0, 16, 0, '0);
    chk("R1 block ale address", ale_addr, 32'h0000_6000);
    chk("R10 imiss addr diag", 32'(diag_a), 32'd1);
    chk("R10 imiss data diag", 32'(diag_d), 32'd1);
    tb_w = 4; tb_big = 1;
    run(0, 2'd2, 2'd1, 32'h0000_6104, 2'd1, '0, 0);
    expect_seq("R3 block32 be", 4, 0, 16, 0, '0);
  endtask

  task automatic t_dmiss;
    tb_w = 4; tb_big = 0; cfg_dref4 = 0;
    run(0, 2'd0, 2'd2, 32'h0000_700C, 2'd1, '0, 0);
    expect_seq("R12 dmiss single", 4, 32'h700C, 4, 0, '0);
    chk("R10 dmiss addr diag", 32'(diag_a), 32'd1);
    chk("R10 dmiss data diag", 32'(diag_d), 32'd0);
    cfg_dref4 = 1;
    run(0, 2'd0, 2'd2, 32'h0000_700C, 2'd1, '0, 0);
    expect_seq("R12 dmiss block", 4, 0, 16, 0, '0);
    chk("R12 dmiss block ale", ale_addr, 32'h0000_7000);
    cfg_dref4 = 0;
  endtask

  task automatic t_strobe_modes;
    tb_w = 4; tb_big = 0; cfg_strb = 4'b11_00;
    run(0, 2'd2, 2'd0, 32'h0000_0100, 2'd1, '0, 0);
    chk("R9 both-mode read", 32'(strb_d), 32'b10);
    run(1, 2'd2, 2'd0, 32'h0000_0100, 2'd1, 32'h1, 0);
    chk("R9 both-mode write", 32'(strb_d), 32'b10);
    cfg_strb = 4'b10_01;
  endtask

  task automatic t_turn;
    tb_w = 4; tb_big = 0; cfg_turn = 2'd0;
    run(0, 2'd2, 2'd0, 32'h0000_0200, 2'd1, '0, 0);
    cfg_turn = 2'd2;
    run(0, 2'd2, 2'd0, 32'h0000_0204, 2'd1, '0, 0);
    chk("R7 read after read", 32'(t_ale), 32'd1);
    run(1, 2'd2, 2'd0, 32'h0000_0208, 2'd1, 32'h9, 0);
    chk("R7 write after read", 32'(t_ale), 32'd3);
    run(1, 2'd2, 2'd0, 32'h0000_020C, 2'd1, 32'h9, 0);
    chk("R7 write after write", 32'(t_ale), 32'd1);
    run(0, 2'd2, 2'd0, 32'h0000_0210, 2'd1, '0, 0);
    chk("R7 read after write", 32'(t_ale), 32'd3);
    chk("R8 no hold gap", 32'(t_data - t_ale), 32'd1);
    cfg_turn = 2'd0;
  endtask

  task automatic t_straps;
    tb_w = 4; tb_big = 0;
    run(0, 2'd2, 2'd0, 32'h0000_0010, 2'd0, '0, 0);
    expect_seq("R11 boot32", 4, 32'h10, 4, 0, '0);
    do_reset(3'b101);
    tb_w = 1;
    run(0, 2'd2, 2'd0, 32'h0000_0020, 2'd0, '0, 0);
    expect_seq("R11 boot8", 1, 32'h20, 4, 0, '0);
    chk("R8 hold gap", 32'(t_data - t_ale), 32'd2);
    chk("R8 hold drives", 32'(hold_oe), 32'd1);
    chk("R8 hold address", hold_addr, ale_addr);
    do_reset(3'b010);
    tb_w = 2;
    run(0, 2'd2, 2'd0, 32'h0000_0030, 2'd0, '0, 0);
    expect_seq("R11 boot16", 2, 32'h30, 4, 0, '0);
    chk("R8 hold off", 32'(t_data - t_ale), 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog R2 act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(3'b000);
    @(negedge clk);
    t_reset();
    t_word32();
    t_pack8_stall();
    t_byte16();
    t_writes();
    t_block();
    t_dmiss();
    t_strobe_modes();
    t_turn();
    t_straps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule